// File: doc/BRIEF.md
# Adaptive Base Register Value Cache

This block is a small, fully associative store of register values. Early load address generation uses it to get the base operand of an effective address without waiting for the register file. A lookup names an architectural register. The cache answers in the same cycle with a hit flag and the cached value. Writebacks to cached registers refresh the stored value. After a miss, the pipeline inserts the register through the allocate port.

When the cache is full, a victim is chosen either by recency (least recently used) or by frequency (least frequently used). Two tag-only shadow directories watch the lookup stream. One behaves as a pure recency cache and the other as a pure frequency cache. A saturating selector leans toward whichever of them is currently scoring hits that the other misses. The selector's top bit decides the policy the real cache uses at the moment of each allocation.

Top module: `base_value_cache`

## Requirements
- R1: The cache has ENTRIES (default 4) fully associative slots. Once a register is allocated, a lookup of it (lk_valid high) reports lk_hit=1 from the next cycle on, in the same cycle as the lookup, until it is evicted. lk_hit is 0 when lk_valid is low or the register is absent.
- R2: On a hit, lk_data is the stored value. If wb_valid targets the same cached register in the same cycle, lk_data is wb_data instead. On a miss, lk_data is 0.
- R3: A writeback to a cached register replaces its value from the next cycle on and leaves its recency and frequency standing unchanged. A writeback to an uncached register has no effect.
- R4: An allocation of an absent register fills the lowest-index empty slot while any slot is empty. No valid register is evicted until all slots are full.
- R5: In recency mode (policy_lfu=0), a full cache evicts the register whose last use is oldest. A use is a lookup hit or an allocation.
- R6: In frequency mode (policy_lfu=1), a full cache evicts the register with the smallest use count. Ties go to the lowest slot index. An allocation sets the count to 1, and a lookup hit raises it by 1.
- R7: When an increment brings any count to its maximum (15 for 4-bit counts), every count in that directory is halved in the same update. The real cache and the frequency shadow behave the same way in this respect.
- R8: On every valid lookup, both shadow directories update: a hit refreshes the register, and a miss inserts it using their own fixed policy. A 4-bit selector starts at 7. It steps up, saturating at 15, when only the frequency shadow hits. It steps down, saturating at 0, when only the recency shadow hits. policy_lfu is the selector's top bit.
- R9: An allocation of a register that is already cached only rewrites its value. Nothing is evicted, and its recency and count are unchanged.
- R10: When an allocation of an absent register and a lookup hit happen in the same cycle, only the allocation updates recency and counts in the real cache. The shadows still see the lookup.
- R11: After reset, every slot is empty, the selector is 7 and policy_lfu is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_reg | input | REG_W | Register number looked up |
| lk_hit | output | 1 | Lookup hit |
| lk_data | output | DATA_W | Value of the looked-up register |
| wb_valid | input | 1 | Register writeback |
| wb_reg | input | REG_W | Register number written back |
| wb_data | input | DATA_W | Written-back value |
| al_valid | input | 1 | Allocate request |
| al_reg | input | REG_W | Register number to insert |
| al_data | input | DATA_W | Value to insert |
| policy_lfu | output | 1 | 1 when frequency replacement is active |

## Verification
The bench builds the block with 4 slots, 4-bit counts and selector, a 16-bit datapath and REG_W=3. The small namespace of 8 registers against 4 slots makes evictions, shadow disagreements and counter halving frequent. Over a few thousand lookups, the bench alternates random, cyclic (5 and 6 registers) and hot-set patterns. This drives the selector to both ends. Every cycle is compared against a timestamp- and count-based model.

// File: rtl/base_value_cache.sv
module base_value_cache #(
  parameter int ENTRIES = 4,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 32,
  parameter int FREQ_W  = 4,
  parameter int SEL_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [REG_W-1:0]  lk_reg,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  input  logic              wb_valid,
  input  logic [REG_W-1:0]  wb_reg,
  input  logic [DATA_W-1:0] wb_data,
  input  logic              al_valid,
  input  logic [REG_W-1:0]  al_reg,
  input  logic [DATA_W-1:0] al_data,
  output logic              policy_lfu
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [SEL_W-1:0] SEL_INIT = {1'b0, {(SEL_W-1){1'b1}}};

  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [ENTRIES-1:0] vec_t;
  typedef logic [ENTRIES-1:0][IDX_W-1:0] rank_t;
  typedef logic [ENTRIES-1:0][FREQ_W-1:0] freq_t;
  typedef logic [ENTRIES-1:0][REG_W-1:0] tag_t;

  function automatic vec_t match_f(tag_t t, vec_t v, logic [REG_W-1:0] r);
    vec_t m;
    for (int i = 0; i < ENTRIES; i++) m[i] = v[i] && (t[i] == r);
    return m;
  endfunction

  function automatic idx_t enc_f(vec_t oh);
    idx_t e = '0;
    for (int i = 0; i < ENTRIES; i++) if (oh[i]) e = idx_t'(i);
    return e;
  endfunction

  function automatic idx_t free_f(vec_t v);
    idx_t e = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) if (!v[i]) e = idx_t'(i);
    return e;
  endfunction

  function automatic idx_t oldest_f(rank_t r);
    idx_t e = '0;
    for (int i = 0; i < ENTRIES; i++) if (r[i] == idx_t'(ENTRIES - 1)) e = idx_t'(i);
    return e;
  endfunction

  function automatic idx_t rarest_f(freq_t f);
    int best = 0;
    for (int i = 1; i < ENTRIES; i++) if (f[i] < f[best]) best = i;
    return idx_t'(best);
  endfunction

  function automatic rank_t promote_f(rank_t r, idx_t e);
    rank_t o;
    for (int i = 0; i < ENTRIES; i++) begin
      if (idx_t'(i) == e)   o[i] = '0;
      else if (r[i] < r[e]) o[i] = r[i] + idx_t'(1);
      else                  o[i] = r[i];
    end
    return o;
  endfunction

  function automatic freq_t bump_f(freq_t f, idx_t e);
    freq_t o = f;
    o[e] = f[e] + FREQ_W'(1);
    if (&o[e]) for (int i = 0; i < ENTRIES; i++) o[i] = o[i] >> 1;
    return o;
  endfunction

  // real cache state
  vec_t  valid;
  tag_t  tag;
  rank_t rank;
  freq_t freq;
  logic [ENTRIES-1:0][DATA_W-1:0] data;

  // shadow directories
  vec_t  lv, fv;
  tag_t  lt, ft;
  rank_t lr;
  freq_t ff;
  logic [SEL_W-1:0] sel;

  vec_t lk_oh, wb_oh, al_oh, sl_oh, sf_oh;
  idx_t lk_idx, al_idx, victim, sl_idx, sf_idx;
  logic al_new, sl_hit, sf_hit;

  assign lk_oh  = match_f(tag, valid, lk_reg);
  assign lk_idx = enc_f(lk_oh);
  assign lk_hit = lk_valid && (|lk_oh);
  assign lk_data = !lk_hit ? '0 :
                   (wb_valid && wb_reg == lk_reg) ? wb_data : data[lk_idx];

  assign wb_oh  = match_f(tag, valid, wb_reg);
  assign al_oh  = match_f(tag, valid, al_reg);
  assign al_idx = enc_f(al_oh);
  assign al_new = al_valid && !(|al_oh);
  assign victim = !(&valid) ? free_f(valid) :
                  policy_lfu ? rarest_f(freq) : oldest_f(rank);

  assign policy_lfu = sel[SEL_W-1];

  assign sl_oh  = match_f(lt, lv, lk_reg);
  assign sl_hit = |sl_oh;
  assign sl_idx = sl_hit ? enc_f(sl_oh) : (!(&lv) ? free_f(lv) : oldest_f(lr));
  assign sf_oh  = match_f(ft, fv, lk_reg);
  assign sf_hit = |sf_oh;
  assign sf_idx = sf_hit ? enc_f(sf_oh) : (!(&fv) ? free_f(fv) : rarest_f(ff));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= '0;
      tag   <= '0;
      freq  <= '0;
      data  <= '0;
      for (int i = 0; i < ENTRIES; i++) rank[i] <= idx_t'(i);
    end else begin
      if (al_new) begin
        valid[victim] <= 1'b1;
        tag[victim]   <= al_reg;
        data[victim]  <= al_data;
        rank          <= promote_f(rank, victim);
        freq[victim]  <= FREQ_W'(1);
      end else begin
        if (al_valid) data[al_idx] <= al_data;
        if (lk_hit) begin
          rank <= promote_f(rank, lk_idx);
          freq <= bump_f(freq, lk_idx);
        end
      end
      for (int i = 0; i < ENTRIES; i++)
        if (wb_valid && wb_oh[i] && !(al_new && victim == idx_t'(i))) data[i] <= wb_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lv <= '0;
      lt <= '0;
      fv <= '0;
      ft <= '0;
      ff <= '0;
      sel <= SEL_INIT;
      for (int i = 0; i < ENTRIES; i++) lr[i] <= idx_t'(i);
    end else if (lk_valid) begin
      lr <= promote_f(lr, sl_idx);
      if (!sl_hit) begin
        lv[sl_idx] <= 1'b1;
        lt[sl_idx] <= lk_reg;
      end
      if (sf_hit) ff <= bump_f(ff, sf_idx);
      else begin
        fv[sf_idx] <= 1'b1;
        ft[sf_idx] <= lk_reg;
        ff[sf_idx] <= FREQ_W'(1);
      end
      if (sf_hit && !sl_hit && !(&sel)) sel <= sel + SEL_W'(1);
      if (sl_hit && !sf_hit && (|sel))  sel <= sel - SEL_W'(1);
    end
  end

  // checks on the guarded logic
  vec_t rank_top, freq_full;
  always_comb
    for (int i = 0; i < ENTRIES; i++) begin
      rank_top[i]  = (rank[i] == '0);
      freq_full[i] = &freq[i];
    end

  assert_alloc_hits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    al_valid |=> |match_f(tag, valid, $past(al_reg)));
  assert_wb_keeps_meta_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !al_valid && !lk_hit) |=> ($stable(rank) && $stable(freq)));
  assert_fill_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (al_new && !(&valid)) |=> $countones(valid) == $countones($past(valid)) + 1);
  assert_rank_unique_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rank_top) == 1);
  assert_freq_below_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
    freq_full == '0);
  assert_sel_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == $past(sel)) || (sel == $past(sel) + SEL_W'(1)) || (sel == $past(sel) - SEL_W'(1)));
  assert_present_alloc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (al_valid && !al_new && !lk_hit) |=> ($stable(valid) && $stable(tag) && $stable(rank)));
endmodule

// File: tb/test_base_value_cache.sv
module test_base_value_cache;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int RW = 3;
  localparam int DW = 16;

  logic clk = 0, rst_n = 0;
  logic lk_valid = 0, wb_valid = 0, al_valid = 0;
  logic [RW-1:0] lk_reg = 0, wb_reg = 0, al_reg = 0;
  logic [DW-1:0] wb_data = 0, al_data = 0, lk_data;
  logic lk_hit, policy_lfu;

  base_value_cache #(.ENTRIES(N), .REG_W(RW), .DATA_W(DW), .FREQ_W(4), .SEL_W(4)) i_base_value_cache (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_reg(lk_reg), .lk_hit(lk_hit),
    .lk_data(lk_data), .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data),
    .al_valid(al_valid), .al_reg(al_reg), .al_data(al_data), .policy_lfu(policy_lfu));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  // model: set 0 real, 1 recency shadow, 2 frequency shadow
  int V[3][N], T[3][N], TS[3][N], C[3][N];
  int md[N];
  int msel = 7, now = 0;
  int last_hit, last_data;
  logic [31:0] lfsr = 32'h1234_5678;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int find(int s, int r);
    for (int i = 0; i < N; i++) if (V[s][i] != 0 && T[s][i] == r) return i;
    return -1;
  endfunction

  function automatic int pick(int s, bit lfu);
    int b = 0;
    for (int i = 0; i < N; i++) if (V[s][i] == 0) return i;
    for (int i = 1; i < N; i++)
      if (lfu ? (C[s][i] < C[s][b]) : (TS[s][i] < TS[s][b])) b = i;
    return b;
  endfunction

  task automatic use_e(int s, int i);
    TS[s][i] = now;
    C[s][i]++;
    if (C[s][i] == 15) for (int k = 0; k < N; k++) C[s][k] = C[s][k] / 2;
  endtask

  task automatic put(int s, int i, int r);
    V[s][i] = 1; T[s][i] = r; TS[s][i] = now; C[s][i] = 1;
  endtask

  task automatic step(bit lkv, int lkr, bit wbv, int wbr, int wbd, bit alv, int alr, int ald);
    int rh, wi, ai, vi, sl, sf;
    bit anew;
    @(negedge clk);
    lk_valid = lkv; lk_reg = RW'(lkr); wb_valid = wbv; wb_reg = RW'(wbr); wb_data = DW'(wbd);
    al_valid = alv; al_reg = RW'(alr); al_data = DW'(ald);
    #2;
    rh = lkv ? find(0, lkr) : -1;
    last_hit = (rh >= 0);
    last_data = (rh < 0) ? 0 : (wbv && wbr == lkr) ? wbd : md[rh];
    check("R1 R4 R5 R6 R7 R10 lookup hit", int'(lk_hit), last_hit);
    check("R2 R3 R9 lookup data", int'(lk_data), last_data);
    check("R8 policy", int'(policy_lfu), int'(msel >= 8));
    @(posedge clk);
    now++;
    wi = wbv ? find(0, wbr) : -1;
    ai = alv ? find(0, alr) : -1;
    anew = alv && ai < 0;
    vi = -1;
    if (anew) begin
      vi = pick(0, msel >= 8);
      put(0, vi, alr);
      md[vi] = ald;
    end else begin
      if (alv) md[ai] = ald;
      if (rh >= 0) use_e(0, rh);
    end
    if (wi >= 0 && wi != vi) md[wi] = wbd;
    if (lkv) begin
      sl = find(1, lkr);
      sf = find(2, lkr);
      if (sl >= 0) TS[1][sl] = now; else put(1, pick(1, 0), lkr);
      if (sf >= 0) use_e(2, sf); else put(2, pick(2, 1), lkr);
      if (sf >= 0 && sl < 0 && msel < 15) msel++;
      if (sl >= 0 && sf < 0 && msel > 0) msel--;
    end
  endtask

  task automatic look(int r);
    step(1, r, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic alloc(int r, int d);
    step(0, 0, 0, 0, 0, 1, r, d);
  endtask

  function automatic int rnd();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return int'(lfsr[15:0]);
  endfunction

  initial begin
    repeat (CLK_PERIOD * 15000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int s = 0; s < 3; s++) for (int i = 0; i < N; i++) begin
      V[s][i] = 0; T[s][i] = 0; TS[s][i] = 0; C[s][i] = 0;
    end
    for (int i = 0; i < N; i++) md[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R11: empty after reset, recency policy
    look(0);
    check("R11 empty after reset", last_hit, 0);
    check("R11 policy after reset", int'(policy_lfu), 0);

    // R1 R4: four fills, all resident
    for (int r = 1; r <= 4; r++) alloc(r, 'h100 + r);
    for (int r = 1; r <= 4; r++) begin
      look(r);
      check("R1 R4 filled register hits", last_hit, 1);
      check("R1 R4 filled value", last_data, 'h100 + r);
    end

    // R3 writeback value without refresh; R2 bypass
    step(0, 0, 1, 1, 'h111, 0, 0, 0);
    step(0, 0, 1, 4, 'h444, 0, 0, 0);
    look(4);
    check("R3 writeback value", last_data, 'h444);
    step(1, 3, 1, 3, 'h333, 0, 0, 0);
    check("R2 same-cycle bypass", last_data, 'h333);

    // R5: register 1 is oldest despite its writeback
    alloc(5, 'h105);
    look(1);
    check("R5 R3 oldest evicted", last_hit, 0);
    look(2);
    check("R5 survivor value", last_data, 'h102);
    look(5);
    check("R5 new register", last_data, 'h105);

    // R3: writeback to uncached register ignored
    step(0, 0, 1, 7, 'h777, 0, 0, 0);
    look(7);
    check("R3 uncached writeback ignored", last_hit, 0);

    // R9: allocation of present register only rewrites value
    alloc(2, 'h202);
    look(2);
    check("R9 present rewrite", last_data, 'h202);
    look(3);
    check("R9 no eviction", last_data, 'h333);
    look(4);
    check("R9 no eviction", last_data, 'h444);

    // R8: cyclic reuse beyond capacity favours frequency
    for (int k = 0; k < 60; k++) begin
      look(k % 5 + 1);
      if (!last_hit) alloc(k % 5 + 1, k);
    end
    check("R8 cyclic pattern selects frequency", int'(policy_lfu), 1);

    // mixed sweep: R6 R7 R10 against model
    for (int n = 0; n < 4000; n++) begin
      int kind, r, x;
      kind = (n / 400) % 4;
      x = rnd();
      case (kind)
        0: r = x % 8;
        1: r = n % 5;
        2: r = (x % 4 != 0) ? x % 3 : (x >> 4) % 8;
        default: r = n % 6 + 2;
      endcase
      step(1, r, x[3:2] == 0, (x >> 5) % 8, rnd(), 0, 0, 0);
      if (!last_hit) begin
        x = rnd();
        step(x[0], (x >> 1) % 8, x[5:4] == 0, (x >> 6) % 8, rnd(), 1, r, rnd());
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule